// File: doc/BRIEF.md
# Debug Register Access Controller

This block holds a processor's debug register file and decides whether each move-to or move-from debug register operation is allowed. An access presents a 3-bit register index, a read or write strobe, write data and the current execution context: privilege level, a real-mode flag and the debug-extensions enable. One cycle later the block reports exactly one of three outcomes. It returns registered read data, raises an undefined-opcode fault, or raises a general-protection fault, which always carries error code zero. A faulting access never changes any register.

Indices 0 to 3 are breakpoint address registers. Index 6 is the status register and index 7 is the control register. Indices 4 and 5 depend on the debug-extensions enable. With it clear, they are aliases of 6 and 7. With it set, they are reserved and fault as undefined opcodes. That check ranks above the privilege check.

The response logic is a small state machine, reloaded on every cycle:
- RSP_IDLE: no access, or a write that succeeded.
- RSP_DATA: a read that succeeded.
- RSP_UD: a reserved-index fault.
- RSP_GP: a privilege fault.

From any state, the next state is chosen as follows:
- No strobe leads to RSP_IDLE.
- An access that passes both checks leads to RSP_DATA for a read and to RSP_IDLE for a write.
- A reserved index leads to RSP_UD.
- Otherwise, a privilege failure leads to RSP_GP.

Top module: `dbg_reg_ctrl`

## Requirements
- R1: After reset, breakpoint registers 0 to 3 read 0x00000000, the status register reads 0xFFFF0FF0, the control register reads 0x00000400, and all outputs are low.
- R2: With the debug-extensions enable set and index 4 or 5 (index bits [2:1] equal 2'b10), the access gives `fault_ud` in the next cycle and no `fault_gp`, whatever the privilege level and mode.
- R3: Outside real mode with a privilege level other than 0, and when R2 does not apply, the access gives `fault_gp` in the next cycle, meaning a general-protection fault with error code zero. In real mode, a nonzero privilege level is allowed.
- R4: With the debug-extensions enable clear, index 4 reads and writes the status register and index 5 reads and writes the control register.
- R5: A status write keeps the old bits under mask 0xFFFF0FF0 and takes bits 0–3 and 12–15 from the write data.
- R6: With `NEWER_CORE`=1 (the default), status bit 12 always reads 0. With `NEWER_CORE`=0, that bit is writable.
- R7: The control register stores all 32 written bits, including the exact-match enables in bits 8 and 9, and returns them unchanged. Those bits have no other effect.
- R8: Breakpoint registers 0 to 3 store and return full 32-bit values.
- R9: A read gives exactly one of `rd_valid`, `fault_ud` or `fault_gp` one cycle after the strobe. `rd_data` is zero whenever `rd_valid` is low.
- R10: A faulting write leaves every register unchanged.
- R11: Outputs are single-cycle. A cycle without a strobe is followed by all three response flags low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe |
| acc_write | input | 1 | 1 = move to debug register, 0 = move from |
| acc_idx | input | 3 | Debug register index 0..7 |
| acc_wdata | input | 32 | Write data |
| cpl | input | 2 | Current privilege level |
| real_mode | input | 1 | Processor is in real mode |
| dbg_ext_en | input | 1 | Debug-extensions enable |
| rd_data | output | 32 | Registered read data, zero unless rd_valid |
| rd_valid | output | 1 | Read completed |
| fault_ud | output | 1 | Undefined-opcode fault |
| fault_gp | output | 1 | General-protection fault, error code 0 |

## Verification
The hardest situation to reach is a collision of faults: a reserved index 4 or 5 with the enable set, combined with a nonzero privilege outside real mode, and arriving on a write. Here the priority and the hold on state must both be right.

The random stimulus draws the enable, the mode and the privilege level with high probability and draws indices uniformly, so these collisions occur many times. Directed cases force them once at the start. Every faulting write is followed, within the random stream, by reads that expose any register it might have corrupted.

// File: rtl/dbgreg_pkg.sv
package dbgreg_pkg;
    localparam int unsigned IDX_W    = 3;
    localparam int unsigned BP_COUNT = 4;
    localparam logic [IDX_W-1:0] IDX_STS = 3'd6;
    localparam logic [IDX_W-1:0] IDX_CTL = 3'd7;

    typedef enum logic [1:0] {
        VERD_OK,
        VERD_UD,
        VERD_GP
    } verdict_e;

    typedef enum logic [1:0] {
        RSP_IDLE,
        RSP_DATA,
        RSP_UD,
        RSP_GP
    } rsp_state_e;
endpackage

// File: rtl/dbgreg_access_chk.sv
module dbgreg_access_chk
    import dbgreg_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    input  logic [1:0]       cpl,
    input  logic             real_mode,
    input  logic             ext_en,
    output verdict_e         verdict,
    output logic [IDX_W-1:0] eff_idx
);
    logic alias_hit;
    logic reserved;
    logic priv_bad;

    always_comb begin
        alias_hit = (idx[2:1] == 2'b10);
        reserved  = ext_en && alias_hit;
        priv_bad  = !real_mode && (cpl != 2'd0);
        // reserved-index check ranks above privilege (R2 before R3)
        if (reserved)
            verdict = VERD_UD;
        else if (priv_bad)
            verdict = VERD_GP;
        else
            verdict = VERD_OK;
        // 4 -> 6, 5 -> 7 (R4)
        eff_idx = alias_hit ? {2'b11, idx[0]} : idx;
    end
endmodule

// File: rtl/dbgreg_file.sv
module dbgreg_file
    import dbgreg_pkg::*;
#(
    parameter int unsigned DATA_W     = 32,
    parameter logic [31:0] STS_KEEP   = 32'hFFFF_0FF0,
    parameter logic [31:0] STS_RST    = 32'hFFFF_0FF0,
    parameter logic [31:0] CTL_RST    = 32'h0000_0400,
    parameter bit          NEWER_CORE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned BP_SEL_W = $clog2(BP_COUNT);
    localparam logic [DATA_W-1:0] KEEP_M  = STS_KEEP[DATA_W-1:0];
    localparam logic [DATA_W-1:0] FORCE0  = NEWER_CORE ? DATA_W'(1 << 12) : '0;

    logic [DATA_W-1:0] bp_q [BP_COUNT];
    logic [DATA_W-1:0] sts_q;
    logic [DATA_W-1:0] ctl_q;
    logic [DATA_W-1:0] sts_next;

    for (genvar g = 0; g < BP_COUNT; g++) begin : g_bp
        always_ff @(posedge clk) begin
            if (!rst_n)
                bp_q[g] <= '0;
            else if (wr_en && sel == IDX_W'(g))
                bp_q[g] <= wdata;
        end
    end

    always_comb begin
        sts_next = ((sts_q & KEEP_M) | (wdata & ~KEEP_M)) & ~FORCE0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_q <= STS_RST[DATA_W-1:0] & ~FORCE0;
            ctl_q <= CTL_RST[DATA_W-1:0];
        end else if (wr_en) begin
            if (sel == IDX_STS) sts_q <= sts_next;
            if (sel == IDX_CTL) ctl_q <= wdata;
        end
    end

    always_comb begin
        if (sel < IDX_W'(BP_COUNT))
            rdata = bp_q[sel[BP_SEL_W-1:0]];
        else if (sel == IDX_STS)
            rdata = sts_q;
        else if (sel == IDX_CTL)
            rdata = ctl_q;
        else
            rdata = '0;
    end

    // R5: masked status bits never move on a status write
    a_r5_keep_bits : assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == IDX_STS) |=> ((sts_q & KEEP_M) == ($past(sts_q) & KEEP_M)));

    // R10: without an accepted write, status and control hold
    a_r10_hold_state : assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(sts_q) && $stable(ctl_q)));

    if (NEWER_CORE) begin : g_newer_chk
        // R6: bit 12 of status never becomes set
        a_r6_bit12_zero : assert property (@(posedge clk) disable iff (!rst_n)
            wr_en |=> !sts_q[12]);
    end
endmodule

// File: rtl/dbg_reg_ctrl.sv
module dbg_reg_ctrl
    import dbgreg_pkg::*;
#(
    parameter int unsigned DATA_W     = 32,
    parameter logic [31:0] STS_KEEP   = 32'hFFFF_0FF0,
    parameter logic [31:0] STS_RST    = 32'hFFFF_0FF0,
    parameter logic [31:0] CTL_RST    = 32'h0000_0400,
    parameter bit          NEWER_CORE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [2:0]        acc_idx,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic [1:0]        cpl,
    input  logic              real_mode,
    input  logic              dbg_ext_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              fault_ud,
    output logic              fault_gp
);
    verdict_e          verdict;
    logic [IDX_W-1:0]  eff_idx;
    logic              wr_en;
    logic [DATA_W-1:0] file_rdata;
    rsp_state_e        state_q, state_d;
    logic [DATA_W-1:0] data_q, data_d;

    dbgreg_access_chk u_chk (
        .idx       (acc_idx),
        .cpl       (cpl),
        .real_mode (real_mode),
        .ext_en    (dbg_ext_en),
        .verdict   (verdict),
        .eff_idx   (eff_idx)
    );

    assign wr_en = acc_valid && acc_write && (verdict == VERD_OK);

    dbgreg_file #(
        .DATA_W     (DATA_W),
        .STS_KEEP   (STS_KEEP),
        .STS_RST    (STS_RST),
        .CTL_RST    (CTL_RST),
        .NEWER_CORE (NEWER_CORE)
    ) u_file (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .sel   (eff_idx),
        .wdata (acc_wdata),
        .rdata (file_rdata)
    );

    always_comb begin
        state_d = RSP_IDLE;
        data_d  = '0;
        if (acc_valid) begin
            unique case (verdict)
                VERD_UD: state_d = RSP_UD;
                VERD_GP: state_d = RSP_GP;
                default: begin
                    if (!acc_write) begin
                        state_d = RSP_DATA;
                        data_d  = file_rdata;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RSP_IDLE;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            data_q  <= data_d;
        end
    end

    always_comb begin
        rd_valid = 1'b0;
        fault_ud = 1'b0;
        fault_gp = 1'b0;
        rd_data  = '0;
        unique case (state_q)
            RSP_DATA: begin
                rd_valid = 1'b1;
                rd_data  = data_q;
            end
            RSP_UD:   fault_ud = 1'b1;
            RSP_GP:   fault_gp = 1'b1;
            default:  ;
        endcase
    end

    a_r2_ud_first : assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && dbg_ext_en && acc_idx[2:1] == 2'b10) |=> (fault_ud && !fault_gp));

    a_r3_gp_priv : assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !(dbg_ext_en && acc_idx[2:1] == 2'b10) && !real_mode && cpl != 2'd0)
        |=> (fault_gp && !fault_ud));

    a_r9_one_outcome : assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write) |=> ($countones({rd_valid, fault_ud, fault_gp}) == 1));

    a_r9_zero_data : assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_data == '0));

    a_r11_quiet : assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !(rd_valid || fault_ud || fault_gp));
endmodule

// File: tb/dbg_reg_ctrl_tb.sv
`timescale 1ns/1ps
module dbg_reg_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [2:0]  acc_idx = '0;
    logic [31:0] acc_wdata = '0;
    logic [1:0]  cpl = '0;
    logic        real_mode = 1'b0;
    logic        dbg_ext_en = 1'b0;
    logic [31:0] rd_data;
    logic        rd_valid, fault_ud, fault_gp;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] m_bp [4];
    logic [31:0] m_sts, m_ctl;

    always #4 clk = ~clk;

    dbg_reg_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_idx(acc_idx), .acc_wdata(acc_wdata), .cpl(cpl), .real_mode(real_mode),
        .dbg_ext_en(dbg_ext_en), .rd_data(rd_data), .rd_valid(rd_valid),
        .fault_ud(fault_ud), .fault_gp(fault_gp)
    );

    // 0 ok, 1 ud, 2 gp
    function automatic int verdict_of(input logic [2:0] idx, input logic [1:0] pl,
                                      input logic rm, input logic de);
        if (de && (idx == 3'd4 || idx == 3'd5)) return 1;
        if (!rm && pl != 2'd0) return 2;
        return 0;
    endfunction

    function automatic logic [31:0] model_read(input logic [2:0] idx);
        case (idx)
            3'd0, 3'd1, 3'd2, 3'd3: return m_bp[idx[1:0]];
            3'd4, 3'd6: return m_sts;
            default: return m_ctl;
        endcase
    endfunction

    task automatic expect_val(input string tag, input string what,
                              input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic access(input logic w, input logic [2:0] idx, input logic [31:0] wd,
                          input logic [1:0] pl, input logic rm, input logic de,
                          input string tag);
        int v;
        logic [31:0] exp_data;
        logic [2:0] flags;
        v = verdict_of(idx, pl, rm, de);
        exp_data = (v == 0 && !w) ? model_read(idx) : 32'h0;
        @(negedge clk);
        acc_valid = 1'b1; acc_write = w; acc_idx = idx; acc_wdata = wd;
        cpl = pl; real_mode = rm; dbg_ext_en = de;
        @(negedge clk);
        acc_valid = 1'b0;
        flags = {rd_valid, fault_ud, fault_gp};
        expect_val(tag, "flags{rd,ud,gp}", {29'h0, flags},
                   {29'h0, (v == 0 && !w), (v == 1), (v == 2)});
        expect_val(tag, "rd_data", rd_data, exp_data);
        if (v == 0 && w) begin
            case (idx)
                3'd0, 3'd1, 3'd2, 3'd3: m_bp[idx[1:0]] = wd;
                3'd4, 3'd6: m_sts = ((m_sts & 32'hFFFF0FF0) | (wd & 32'h0000F00F)) & ~32'h00001000;
                default: m_ctl = wd;
            endcase
        end
    endtask

    function automatic string tag_of(input logic [2:0] idx, input int v);
        if (v == 1) return "R2";
        if (v == 2) return "R3";
        if (idx == 3'd4 || idx == 3'd5) return "R4";
        if (idx == 3'd6) return "R5";
        if (idx == 3'd7) return "R7";
        return "R8";
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 4; i++) m_bp[i] = 32'h0;
        m_sts = 32'hFFFF0FF0;
        m_ctl = 32'h00000400;
        repeat (3) @(negedge clk);
        // R1: outputs low while in reset
        expect_val("R1", "flags in reset", {29'h0, rd_valid, fault_ud, fault_gp}, 32'h0);
        rst_n = 1'b1;
        // R1: reset values of every index
        for (int i = 0; i < 8; i++) access(1'b0, 3'(i), 32'h0, 2'd0, 1'b0, 1'b0, "R1");
        // R11: idle cycle after an access
        @(negedge clk);
        expect_val("R11", "idle flags", {29'h0, rd_valid, fault_ud, fault_gp}, 32'h0);
        // R5 R6: status write of all ones
        access(1'b1, 3'd6, 32'hFFFFFFFF, 2'd0, 1'b0, 1'b0, "R5");
        access(1'b0, 3'd6, 32'h0, 2'd0, 1'b0, 1'b0, "R6");
        access(1'b1, 3'd6, 32'h00000000, 2'd0, 1'b0, 1'b0, "R5");
        access(1'b0, 3'd6, 32'h0, 2'd0, 1'b0, 1'b0, "R5");
        // R7: exact-match enables stored
        access(1'b1, 3'd7, 32'h00000300, 2'd0, 1'b0, 1'b0, "R7");
        access(1'b0, 3'd7, 32'h0, 2'd0, 1'b0, 1'b0, "R7");
        // R4: aliases with enable clear
        access(1'b1, 3'd5, 32'hA5A5_0055, 2'd0, 1'b0, 1'b0, "R4");
        access(1'b0, 3'd7, 32'h0, 2'd0, 1'b0, 1'b0, "R4");
        access(1'b1, 3'd4, 32'h0000_A00A, 2'd0, 1'b0, 1'b0, "R4");
        access(1'b0, 3'd6, 32'h0, 2'd0, 1'b0, 1'b0, "R4");
        // R2: reserved index beats privilege, write does not land (R10)
        access(1'b1, 3'd4, 32'h0000_0000, 2'd3, 1'b0, 1'b1, "R2");
        access(1'b1, 3'd5, 32'h1234_5678, 2'd0, 1'b0, 1'b1, "R2");
        access(1'b0, 3'd6, 32'h0, 2'd0, 1'b0, 1'b0, "R10");
        access(1'b0, 3'd7, 32'h0, 2'd0, 1'b0, 1'b0, "R10");
        // R3: privilege fault, real mode exemption, R8 breakpoint
        access(1'b1, 3'd2, 32'hDEAD_BEEF, 2'd3, 1'b0, 1'b0, "R3");
        access(1'b0, 3'd2, 32'h0, 2'd0, 1'b0, 1'b0, "R10");
        access(1'b1, 3'd2, 32'hDEAD_BEEF, 2'd3, 1'b1, 1'b0, "R3");
        access(1'b0, 3'd2, 32'h0, 2'd0, 1'b0, 1'b0, "R8");
        // random mix; R9 covered by every read
        for (int n = 0; n < 600; n++) begin
            logic w; logic [2:0] idx; logic [1:0] pl; logic rm, de;
            w   = $urandom_range(0, 1) == 1;
            idx = 3'($urandom_range(0, 7));
            pl  = ($urandom_range(0, 2) == 0) ? 2'($urandom_range(1, 3)) : 2'd0;
            rm  = $urandom_range(0, 3) == 0;
            de  = $urandom_range(0, 1) == 1;
            access(w, idx, $urandom, pl, rm, de, tag_of(idx, verdict_of(idx, pl, rm, de)));
            if ($urandom_range(0, 7) == 0) begin
                @(negedge clk);
                expect_val("R11", "idle flags", {29'h0, rd_valid, fault_ud, fault_gp}, 32'h0);
            end
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule